// File: doc/BRIEF.md
# Synonym Purge Sequencer for a Virtually-Indexed, Physically-Tagged Cache

When a cache is indexed with virtual address bits that reach above the page offset, one physical line can sit in several sets at once, one for each virtual alias. This sequencer runs at the start of every miss. It takes the miss's virtual index and its translated physical tag, and visits each set where a synonym could be stored. In each set it compares the physical tags of all ways and clears the valid bit of every matching way. The fill then lands in a cache that holds no other copy of the line.

The index bits that lie inside the page offset are the same in every alias, so they are held fixed. Only the index bits above the page offset differ between aliases, and they are stepped through every value. With a 13-bit page offset, a 6-bit block offset and a 9-bit index, two index bits sit above the page offset, which gives four candidate sets. The block drives the tag array through a read port with one cycle of latency and a separate valid-clear port. It signals the miss handler with a one-cycle done pulse, and it reports how many entries it removed.

Top module: `synonym_purge`

## Requirements
- R1: After reset, busy, done, ta_rd_en and ta_clr_en are 0 and inval_count is 0.
- R2: Let miss_start be accepted at a clock edge E. In each of the four cycles that follow E, ta_rd_en is 1. In those cycles, ta_rd_addr[6:0] equals miss_vidx[6:0] and ta_rd_addr[8:7] takes the values 0, 1, 2 and 3 in that order. ta_rd_en is 0 at all other times.
- R3: A way is an alias when its valid bit is 1 and its stored tag equals the latched physical tag. Way i's tag is ta_rd_tag[i*PTAG_W +: PTAG_W]. A way whose tag matches but whose valid bit is 0 is not counted and is not cleared. Every way of a set is compared in the same cycle.
- R4: The set read in the k-th read cycle (k = 0..3) is cleared in cycle k+3 after E. In that cycle ta_clr_en is 1, ta_clr_addr is the address that was read, and bit i of ta_clr_mask is 1 exactly for the alias ways. If the set has no alias, ta_clr_en stays 0 in that cycle.
- R5: busy is 1 from the cycle after E through cycle 5 after E. done is 1 for exactly one cycle, cycle 6 after E, and busy is 0 in that cycle.
- R6: A miss_start that arrives while busy is 1 is ignored. It does not change the walked sets, the compared tag or the timing of done.
- R7: When done is 1, inval_count equals the number of ways cleared by this miss (0 to 16). The value holds until the next accepted miss_start.
- R8: Sets outside the four candidate sets are never read or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_start | input | 1 | Strobe that starts a purge when idle |
| miss_vidx | input | IDX_W | Virtual set index of the missing address |
| miss_ptag | input | PTAG_W | Physical tag of the missing address |
| busy | output | 1 | Purge in progress |
| ta_rd_en | output | 1 | Tag array read request |
| ta_rd_addr | output | IDX_W | Set to read |
| ta_rd_valid | input | WAYS | Valid bits of the set read in the previous cycle |
| ta_rd_tag | input | WAYS*PTAG_W | Tags of the set read in the previous cycle, way 0 in the low bits |
| ta_clr_en | output | 1 | Clear valid bits in one set |
| ta_clr_addr | output | IDX_W | Set whose valid bits are cleared |
| ta_clr_mask | output | WAYS | Ways to invalidate |
| done | output | 1 | One-cycle completion pulse |
| inval_count | output | CNT_W | Number of ways invalidated by the last purge |

## Verification
The bench keeps the default geometry: a 13-bit page offset, a 6-bit block offset, a 9-bit index and four ways. This gives the full four-set alias group and 16 possible hits. The tag width is narrowed to 4 bits, so random tags often collide with the missing tag. Random misses therefore produce mixed hit masks, invalid-but-matching ways, and sets with no alias at all. Directed cases add the 16-hit maximum, the fixed index bits at both extremes next to decoy sets, and a second start strobe in the middle of a walk.

// File: rtl/synpurge_pkg.sv
package synpurge_pkg;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_ISSUE,
        WK_DRAIN
    } walk_state_e;

    // Number of index bits that lie above the page offset
    function automatic int alias_bits(input int idx_w, input int page_w, input int blk_w);
        return idx_w - (page_w - blk_w);
    endfunction

    function automatic logic [7:0] ones_in(input logic [31:0] v);
        logic [7:0] n;
        n = '0;
        for (int i = 0; i < 32; i++) begin
            n = n + 8'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/sp_alias_walker.sv
module sp_alias_walker
    import synpurge_pkg::*;
#(
    parameter int IDX_W   = 9,
    parameter int FIXED_W = 7,
    parameter int GRP_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] vidx,
    output logic             busy,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             cmp_vld,
    output logic             cmp_last,
    output logic [IDX_W-1:0] cmp_addr
);

    walk_state_e        state;
    logic [GRP_W-1:0]   grp;
    logic [FIXED_W-1:0] fixed_q;
    logic               grp_last;

    assign busy     = (state != WK_IDLE);
    assign rd_en    = (state == WK_ISSUE);
    assign rd_addr  = {grp, fixed_q};
    assign grp_last = (grp == {GRP_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WK_IDLE;
            grp      <= '0;
            fixed_q  <= '0;
            cmp_vld  <= 1'b0;
            cmp_last <= 1'b0;
            cmp_addr <= '0;
        end else begin
            cmp_vld  <= rd_en;
            cmp_last <= rd_en && grp_last;
            cmp_addr <= rd_addr;
            case (state)
                WK_IDLE: begin
                    if (start) begin
                        fixed_q <= vidx[FIXED_W-1:0];
                        grp     <= '0;
                        state   <= WK_ISSUE;
                    end
                end
                WK_ISSUE: begin
                    grp <= grp + 1'b1;
                    if (grp_last) state <= WK_DRAIN;
                end
                WK_DRAIN: begin
                    if (cmp_vld && cmp_last) state <= WK_IDLE;
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    AST_WALK_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_en && $past(rd_en) |-> rd_addr[IDX_W-1:FIXED_W] ==
            GRP_W'($past(rd_addr[IDX_W-1:FIXED_W]) + 1'b1)); // R2
    AST_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_en && $past(rd_en) |-> rd_addr[FIXED_W-1:0] == $past(rd_addr[FIXED_W-1:0])); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(rd_addr[FIXED_W-1:0])); // R6

endmodule

// File: rtl/sp_way_match.sv
module sp_way_match #(
    parameter int WAYS   = 4,
    parameter int PTAG_W = 20
) (
    input  logic [WAYS-1:0]        valid,
    input  logic [WAYS*PTAG_W-1:0] tags,
    input  logic [PTAG_W-1:0]      ptag,
    output logic [WAYS-1:0]        hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = valid[w] && (tags[w*PTAG_W +: PTAG_W] == ptag);
    end

endmodule

// File: rtl/sp_inval_stage.sv
module sp_inval_stage
    import synpurge_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 5,
    parameter int MAX_CT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             cmp_vld,
    input  logic             cmp_last,
    input  logic [IDX_W-1:0] cmp_addr,
    input  logic [WAYS-1:0]  hit,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_addr,
    output logic [WAYS-1:0]  clr_mask,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    logic [7:0] hit_n;
    assign hit_n = ones_in(32'(hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_en   <= 1'b0;
            clr_addr <= '0;
            clr_mask <= '0;
            done     <= 1'b0;
            count    <= '0;
        end else begin
            clr_en   <= cmp_vld && (|hit);
            clr_addr <= cmp_addr;
            clr_mask <= cmp_vld ? hit : '0;
            done     <= cmp_vld && cmp_last;
            if (accept)       count <= '0;
            else if (cmp_vld) count <= count + CNT_W'(hit_n);
        end
    end

    AST_CLR_AFTER_CMP: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> $past(cmp_vld)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept && !cmp_vld |=> $stable(count)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(MAX_CT)); // R7

endmodule

// File: rtl/synonym_purge.sv
module synonym_purge
    import synpurge_pkg::*;
#(
    parameter int IDX_W     = 9,
    parameter int PAGE_W    = 13,
    parameter int BLK_W     = 6,
    parameter int WAYS      = 4,
    parameter int PTAG_W    = 20,
    localparam int GRP_W    = alias_bits(IDX_W, PAGE_W, BLK_W),
    localparam int FIXED_W  = IDX_W - GRP_W,
    localparam int MAX_CT   = (1 << GRP_W) * WAYS,
    localparam int CNT_W    = $clog2(MAX_CT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   miss_start,
    input  logic [IDX_W-1:0]       miss_vidx,
    input  logic [PTAG_W-1:0]      miss_ptag,
    output logic                   busy,
    output logic                   ta_rd_en,
    output logic [IDX_W-1:0]       ta_rd_addr,
    input  logic [WAYS-1:0]        ta_rd_valid,
    input  logic [WAYS*PTAG_W-1:0] ta_rd_tag,
    output logic                   ta_clr_en,
    output logic [IDX_W-1:0]       ta_clr_addr,
    output logic [WAYS-1:0]        ta_clr_mask,
    output logic                   done,
    output logic [CNT_W-1:0]       inval_count
);

    logic              accept;
    logic [PTAG_W-1:0] ptag_q;
    logic              cmp_vld;
    logic              cmp_last;
    logic [IDX_W-1:0]  cmp_addr;
    logic [WAYS-1:0]   hit;

    assign accept = miss_start && !busy;

    always_ff @(posedge clk) begin
        if (rst)         ptag_q <= '0;
        else if (accept) ptag_q <= miss_ptag;
    end

    sp_alias_walker #(.IDX_W(IDX_W), .FIXED_W(FIXED_W), .GRP_W(GRP_W)) u_walk (
        .clk(clk), .rst(rst), .start(miss_start), .vidx(miss_vidx),
        .busy(busy), .rd_en(ta_rd_en), .rd_addr(ta_rd_addr),
        .cmp_vld(cmp_vld), .cmp_last(cmp_last), .cmp_addr(cmp_addr)
    );

    sp_way_match #(.WAYS(WAYS), .PTAG_W(PTAG_W)) u_match (
        .valid(ta_rd_valid), .tags(ta_rd_tag), .ptag(ptag_q), .hit(hit)
    );

    sp_inval_stage #(.IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W), .MAX_CT(MAX_CT)) u_inval (
        .clk(clk), .rst(rst), .accept(accept),
        .cmp_vld(cmp_vld), .cmp_last(cmp_last), .cmp_addr(cmp_addr), .hit(hit),
        .clr_en(ta_clr_en), .clr_addr(ta_clr_addr), .clr_mask(ta_clr_mask),
        .done(done), .count(inval_count)
    );

    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        ta_rd_en |-> busy); // R2
    AST_PTAG_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptag_q)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !ta_rd_en); // R5
    AST_CLR_SAME_GROUP: assert property (@(posedge clk) disable iff (rst)
        ta_clr_en |-> ta_clr_addr[FIXED_W-1:0] == $past(ta_rd_addr[FIXED_W-1:0], 2)); // R8

endmodule

// File: tb/tb_synonym_purge.sv
module tb_synonym_purge;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 9;
    localparam int WAYS   = 4;
    localparam int PTAG_W = 4;
    localparam int SETS   = 1 << IDX_W;
    localparam int FIX_W  = 7;
    localparam int CNT_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_start = 1'b0;
    logic [IDX_W-1:0] miss_vidx = '0;
    logic [PTAG_W-1:0] miss_ptag = '0;
    logic busy, ta_rd_en, ta_clr_en, done;
    logic [IDX_W-1:0] ta_rd_addr, ta_clr_addr;
    logic [WAYS-1:0] ta_rd_valid, ta_clr_mask;
    logic [WAYS*PTAG_W-1:0] ta_rd_tag;
    logic [CNT_W-1:0] inval_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    synonym_purge #(.PTAG_W(PTAG_W)) dut (
        .clk(clk), .rst(rst), .miss_start(miss_start), .miss_vidx(miss_vidx),
        .miss_ptag(miss_ptag), .busy(busy), .ta_rd_en(ta_rd_en), .ta_rd_addr(ta_rd_addr),
        .ta_rd_valid(ta_rd_valid), .ta_rd_tag(ta_rd_tag), .ta_clr_en(ta_clr_en),
        .ta_clr_addr(ta_clr_addr), .ta_clr_mask(ta_clr_mask), .done(done),
        .inval_count(inval_count)
    );

    // Tag array model: one-cycle read, valid-clear port
    logic [WAYS-1:0]        mv [SETS];
    logic [WAYS*PTAG_W-1:0] mt [SETS];
    logic [WAYS-1:0]        ev [SETS];

    always @(posedge clk) begin
        if (ta_rd_en) begin
            ta_rd_valid <= mv[ta_rd_addr];
            ta_rd_tag   <= mt[ta_rd_addr];
        end
        if (ta_clr_en) mv[ta_clr_addr] = mv[ta_clr_addr] & ~ta_clr_mask;
    end

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [WAYS-1:0] alias_mask(input logic [WAYS-1:0] v,
            input logic [WAYS*PTAG_W-1:0] t, input logic [PTAG_W-1:0] p);
        logic [WAYS-1:0] m;
        for (int w = 0; w < WAYS; w++) m[w] = v[w] && (t[w*PTAG_W +: PTAG_W] == p);
        return m;
    endfunction

    function automatic int popc(input logic [WAYS-1:0] m);
        int n = 0;
        for (int w = 0; w < WAYS; w++) n += int'(m[w]);
        return n;
    endfunction

    task automatic put_set(input int s, input logic [WAYS-1:0] v,
                           input logic [WAYS*PTAG_W-1:0] t);
        mv[s] = v;
        mt[s] = t;
    endtask

    task automatic run_miss(input logic [IDX_W-1:0] vidx, input logic [PTAG_W-1:0] ptag,
                            input bit intruder);
        logic [WAYS-1:0] em [4];
        int total = 0;
        int bad = 0;
        int first_bad = -1;
        for (int s = 0; s < SETS; s++) ev[s] = mv[s];
        for (int k = 0; k < 4; k++) begin
            int s = k * (1 << FIX_W) + int'(vidx[FIX_W-1:0]);
            em[k] = alias_mask(mv[s], mt[s], ptag);
            total += popc(em[k]);
            ev[s] = ev[s] & ~em[k];
        end
        @(negedge clk);
        miss_start = 1'b1; miss_vidx = vidx; miss_ptag = ptag;
        for (int c = 1; c <= 7; c++) begin
            @(negedge clk);
            if (c == 1 || c == 3) miss_start = 1'b0;
            if (c <= 4) begin
                chk(ta_rd_en == 1'b1, "R2", "read enable in walk", int'(ta_rd_en), 1);
                chk(ta_rd_addr == {2'(c-1), vidx[FIX_W-1:0]}, "R2", "candidate set address",
                    int'(ta_rd_addr), int'({2'(c-1), vidx[FIX_W-1:0]}));
                chk(busy == 1'b1, "R5", "busy during walk", int'(busy), 1);
            end else begin
                chk(ta_rd_en == 1'b0, "R8", "no read outside walk", int'(ta_rd_en), 0);
            end
            if (c == 5) begin
                chk(busy == 1'b1, "R5", "busy in drain cycle", int'(busy), 1);
                chk(done == 1'b0, "R5", "done not early", int'(done), 0);
            end
            if (c <= 2) chk(ta_clr_en == 1'b0, "R4", "no early clear", int'(ta_clr_en), 0);
            if (c >= 3 && c <= 6) begin
                chk(ta_clr_en == (em[c-3] != 0), "R4", "clear enable per set",
                    int'(ta_clr_en), int'(em[c-3] != 0));
                if (em[c-3] != 0) begin
                    chk(ta_clr_mask == em[c-3], "R3", "alias way mask",
                        int'(ta_clr_mask), int'(em[c-3]));
                    chk(ta_clr_addr == {2'(c-3), vidx[FIX_W-1:0]}, "R4", "clear address",
                        int'(ta_clr_addr), int'({2'(c-3), vidx[FIX_W-1:0]}));
                end
            end
            if (c == 6) begin
                chk(done == 1'b1, "R5", "done pulse timing", int'(done), 1);
                chk(busy == 1'b0, "R5", "idle with done", int'(busy), 0);
                chk(int'(inval_count) == total, "R7", "invalidated count", int'(inval_count), total);
            end
            if (c == 7) begin
                chk(done == 1'b0, "R5", "done single cycle", int'(done), 0);
                chk(int'(inval_count) == total, "R7", "count held", int'(inval_count), total);
                if (intruder) chk(busy == 1'b0, "R6", "no second walk", int'(busy), 0);
            end
            if (c == 2 && intruder) begin
                miss_start = 1'b1;
                miss_vidx  = vidx ^ 9'h155;
                miss_ptag  = ~ptag;
            end
        end
        for (int s = 0; s < SETS; s++) begin
            if (mv[s] != ev[s]) begin
                bad++;
                if (first_bad < 0) first_bad = s;
            end
        end
        chk(bad == 0, "R8", "array valid bits after purge", bad, 0);
    endtask

    task automatic rand_group(input logic [IDX_W-1:0] vidx);
        for (int k = 0; k < 4; k++) begin
            int s = k * (1 << FIX_W) + int'(vidx[FIX_W-1:0]);
            logic [WAYS-1:0] v;
            for (int w = 0; w < WAYS; w++) v[w] = ($urandom % 4) != 0;
            put_set(s, v, (WAYS*PTAG_W)'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < SETS; s++) put_set(s, 4'($urandom), (WAYS*PTAG_W)'($urandom));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(ta_rd_en == 1'b0, "R1", "read after reset", int'(ta_rd_en), 0);
        chk(ta_clr_en == 1'b0, "R1", "clear after reset", int'(ta_clr_en), 0);
        chk(inval_count == '0, "R1", "count after reset", int'(inval_count), 0);

        // R4: no alias anywhere in the group
        for (int k = 0; k < 4; k++) put_set(k * 128 + 5, 4'hF, 16'h2222);
        run_miss(9'h005, 4'h7, 1'b0);

        // R7: every way of every candidate set matches (16 hits)
        for (int k = 0; k < 4; k++) put_set(k * 128 + 7'h7F, 4'hF, 16'h9999);
        put_set(0, 4'hF, 16'h9999);
        put_set(128, 4'hF, 16'h9999);
        run_miss(9'h17F, 4'h9, 1'b0);

        // R3: matching tags in invalid ways are left alone
        put_set(0 * 128 + 0, 4'b0010, 16'hAAAA);
        put_set(1 * 128 + 0, 4'b0000, 16'hAAAA);
        put_set(2 * 128 + 0, 4'b1000, 16'hA3A3);
        put_set(3 * 128 + 0, 4'b0101, 16'h3A3A);
        run_miss(9'h000, 4'hA, 1'b0);

        // R6: second start during the walk is ignored
        for (int k = 0; k < 4; k++) put_set(k * 128 + 33, 4'b1011, 16'h5C5C);
        run_miss(9'h021, 4'h5, 1'b1);

        // Random misses
        for (int n = 0; n < 40; n++) begin
            logic [IDX_W-1:0] vi;
            vi = 9'($urandom);
            rand_group(vi);
            run_miss(vi, 4'($urandom), ($urandom % 5) == 0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule